// File: doc/BRIEF.md
# Iterative Floating-Point Adder/Subtractor

This block adds or subtracts two single-word floating-point values. A word holds a sign bit, an 8-bit exponent with a bias of 128 and a 23-bit fraction below an implied leading one. An exponent field of zero encodes the value zero. The block accepts one operation per start pulse. When the result is ready, it raises `done_o` for one cycle and shows the result and two range flags.

The work is done by a phase machine, one phase per state:

| State | What it does | Exits |
|---|---|---|
| `ST_IDLE` | Waits for `start_i` and latches both operands. The second operand's sign is inverted for a subtract. | Goes to `ST_ZCHK`. |
| `ST_ZCHK` | Tests both operands for zero. | If an operand is zero, it goes to `ST_DONE` and returns the other operand. Otherwise it loads the exponents and significands and goes to `ST_ALIGN`. |
| `ST_ALIGN` | Shifts the significand with the smaller exponent right by one bit and raises that exponent by one, once per cycle. | Goes to `ST_ADD` when the exponents are equal. Goes to `ST_DONE` early, returning the larger operand, if the next shift would empty the significand. |
| `ST_ADD` | Combines the aligned significands by sign. | Goes to `ST_DONE` on an exact zero or an exponent overflow. Otherwise it goes to `ST_NORM`. A carry is folded back with one right shift. |
| `ST_NORM` | Shifts left one bit per cycle and lowers the exponent. | Goes to `ST_DONE` when the leading bit is one, or on underflow. |
| `ST_DONE` | Drives `done_o`. | Returns to `ST_IDLE`. |

Top module: `fp_iter_addsub`

## Requirements
- R1: When `sub_i` is 1, bit 31 of the second operand is inverted before any other step, and the rest of the operation runs as an addition.
- R2: If either operand has an exponent field of 0, the other operand (after the R1 sign change) is returned unchanged, with both flags 0. The first operand is tested first.
- R3: Alignment raises the smaller exponent by exactly 1 per cycle, shifting that significand right by one bit, until both exponents are equal. The bits shifted out are dropped.
- R4: If the next alignment shift would make the shifted significand zero, the operation stops and returns the operand with the larger exponent unchanged.
- R5: If the combined significand is exactly zero, the result is the all-zero word with both flags 0.
- R6: A carry out of the significand shifts it right once and raises the exponent by one. If the exponent is already 255, `ovf_o` is set and the result is the computed sign, exponent field 255 and fraction 0.
- R7: Normalization shifts left one bit per cycle and lowers the exponent by one each time, until the implied-one position (bit 23 of the significand) is 1. If the exponent field is 1 and another shift is needed, `unf_o` is set and the result is the all-zero word.
- R8: The word layout is: bit 31 sign, bits 30:23 exponent in excess-128, bits 22:0 fraction. An exponent field of 0 means zero whatever the fraction. Normal results use exponent fields 1 to 255.
- R9: When the signs differ, the result takes the sign of the operand with the larger aligned significand. Rounding is by truncation.
- R10: `done_o` is high for exactly one cycle per accepted start. `result_o`, `ovf_o` and `unf_o` are valid in that cycle. A `start_i` seen while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| result_o | output | 32 | Result word |
| done_o | output | 1 | One-cycle result-valid pulse |
| ovf_o | output | 1 | Exponent overflow flag |
| unf_o | output | 1 | Exponent underflow flag |

## Verification
Some properties are checked by assertions on every cycle:
- each alignment cycle moves exactly one exponent by one;
- each normalization cycle lowers the exponent by one;
- a zero operand leads straight to completion with the other word;
- the overflow and underflow result words are correct;
- the flags never appear together;
- `done_o` lasts a single cycle.

Other behaviour can only be shown by the bench's scenarios. This covers the numeric results: the sign chosen when the signs differ, truncation of shifted-out bits, and the alignment limits at shift distances of 23 and 24. It also covers the exact exponent boundary between a valid minimum result and underflow, and the fact that a start pulse during a long alignment leaves the running operation untouched.

// File: rtl/fpas_pkg.sv
`timescale 1ns/1ps
package fpas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZCHK,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_DONE
    } fpas_state_e;
endpackage

// File: rtl/fpas_unpack.sv
`timescale 1ns/1ps
// Splits a stored word into sign, biased exponent and significand with the
// implied leading one restored; an exponent field of zero marks zero.
module fpas_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [SIG_W-1:0]  sig_o,
    output logic              zero_o
);
    assign sign_o = word_i[WORD_W-1];
    assign exp_o  = word_i[WORD_W-2 -: EXP_W];
    assign sig_o  = {1'b1, word_i[FRAC_W-1:0]};
    assign zero_o = (word_i[WORD_W-2 -: EXP_W] == '0);
endmodule

// File: rtl/fpas_magadd.sv
`timescale 1ns/1ps
// Signed-magnitude combination of two aligned significands.
module fpas_magadd #(
    parameter int SIG_W = 24
) (
    input  logic             sa_i,
    input  logic             sb_i,
    input  logic [SIG_W-1:0] ma_i,
    input  logic [SIG_W-1:0] mb_i,
    output logic [SIG_W:0]   sum_o,
    output logic             sign_o,
    output logic             zero_o
);
    always_comb begin
        if (sa_i == sb_i) begin
            sum_o  = {1'b0, ma_i} + {1'b0, mb_i};
            sign_o = sa_i;
        end else if (ma_i >= mb_i) begin
            sum_o  = {1'b0, ma_i - mb_i};
            sign_o = sa_i;
        end else begin
            sum_o  = {1'b0, mb_i - ma_i};
            sign_o = sb_i;
        end
        zero_o = (sum_o == '0);
    end
endmodule

// File: rtl/fp_iter_addsub.sv
`timescale 1ns/1ps
module fp_iter_addsub
    import fpas_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    sub_i,
    input  logic [EXP_W+FRAC_W:0]   opa_i,
    input  logic [EXP_W+FRAC_W:0]   opb_i,
    output logic [EXP_W+FRAC_W:0]   result_o,
    output logic                    done_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXP_W-1:0] EXP_MIN = {{(EXP_W-1){1'b0}}, 1'b1};

    fpas_state_e state_q, state_d;

    // latched operand words (index 1 already carries the subtract sign flip)
    logic [WORD_W-1:0] w_q [2];
    // working operands
    logic              sa_q, sb_q;
    logic [EXP_W-1:0]  ea_q, eb_q;
    logic [SIG_W-1:0]  ma_q, mb_q;
    // result being normalized
    logic              rs_q;
    logic [EXP_W-1:0]  re_q;
    logic [SIG_W-1:0]  rm_q;
    // registered outputs
    logic [WORD_W-1:0] res_q;
    logic              ovf_q, unf_q;

    // unpacked views of the latched words
    logic [1:0]        un_sign;
    logic [1:0]        un_zero;
    logic [EXP_W-1:0]  un_exp [2];
    logic [SIG_W-1:0]  un_sig [2];

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpas_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word_i (w_q[gi]),
            .sign_o (un_sign[gi]),
            .exp_o  (un_exp[gi]),
            .sig_o  (un_sig[gi]),
            .zero_o (un_zero[gi])
        );
    end

    logic [SIG_W:0] sum;
    logic           sum_sign;
    logic           sum_zero;

    fpas_magadd #(.SIG_W(SIG_W)) u_magadd (
        .sa_i   (sa_q),
        .sb_i   (sb_q),
        .ma_i   (ma_q),
        .mb_i   (mb_q),
        .sum_o  (sum),
        .sign_o (sum_sign),
        .zero_o (sum_zero)
    );

    // phase decisions
    logic a_smaller, exp_equal, align_flush, sum_carry, ovf_now, norm_done, unf_now;
    assign a_smaller   = (ea_q < eb_q);
    assign exp_equal   = (ea_q == eb_q);
    assign align_flush = a_smaller ? ((ma_q >> 1) == '0) : ((mb_q >> 1) == '0);
    assign sum_carry   = sum[SIG_W];
    assign ovf_now     = !sum_zero && sum_carry && (ea_q == EXP_MAX);
    assign norm_done   = rm_q[SIG_W-1];
    assign unf_now     = !norm_done && (re_q == EXP_MIN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ZCHK;
            ST_ZCHK:  state_d = (un_zero[0] || un_zero[1]) ? ST_DONE : ST_ALIGN;
            ST_ALIGN: begin
                if (exp_equal)        state_d = ST_ADD;
                else if (align_flush) state_d = ST_DONE;
            end
            ST_ADD:   state_d = (sum_zero || ovf_now) ? ST_DONE : ST_NORM;
            ST_NORM:  if (norm_done || unf_now) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q[0] <= '0;
            w_q[1] <= '0;
            sa_q   <= 1'b0;
            sb_q   <= 1'b0;
            ea_q   <= '0;
            eb_q   <= '0;
            ma_q   <= '0;
            mb_q   <= '0;
            rs_q   <= 1'b0;
            re_q   <= '0;
            rm_q   <= '0;
            res_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        w_q[0] <= opa_i;
                        w_q[1] <= {opb_i[WORD_W-1] ^ sub_i, opb_i[WORD_W-2:0]};
                        ovf_q  <= 1'b0;
                        unf_q  <= 1'b0;
                    end
                end
                ST_ZCHK: begin
                    if (un_zero[0]) begin
                        res_q <= w_q[1];
                    end else if (un_zero[1]) begin
                        res_q <= w_q[0];
                    end else begin
                        sa_q <= un_sign[0];
                        sb_q <= un_sign[1];
                        ea_q <= un_exp[0];
                        eb_q <= un_exp[1];
                        ma_q <= un_sig[0];
                        mb_q <= un_sig[1];
                    end
                end
                ST_ALIGN: begin
                    if (!exp_equal) begin
                        if (align_flush) begin
                            res_q <= a_smaller ? w_q[1] : w_q[0];
                        end else if (a_smaller) begin
                            ma_q <= ma_q >> 1;
                            ea_q <= ea_q + 1'b1;
                        end else begin
                            mb_q <= mb_q >> 1;
                            eb_q <= eb_q + 1'b1;
                        end
                    end
                end
                ST_ADD: begin
                    if (sum_zero) begin
                        res_q <= '0;
                    end else if (ovf_now) begin
                        ovf_q <= 1'b1;
                        res_q <= {sum_sign, EXP_MAX, {FRAC_W{1'b0}}};
                    end else if (sum_carry) begin
                        rs_q <= sum_sign;
                        re_q <= ea_q + 1'b1;
                        rm_q <= sum[SIG_W:1];
                    end else begin
                        rs_q <= sum_sign;
                        re_q <= ea_q;
                        rm_q <= sum[SIG_W-1:0];
                    end
                end
                ST_NORM: begin
                    if (norm_done) begin
                        res_q <= {rs_q, re_q, rm_q[FRAC_W-1:0]};
                    end else if (unf_now) begin
                        unf_q <= 1'b1;
                        res_q <= '0;
                    end else begin
                        rm_q <= rm_q << 1;
                        re_q <= re_q - 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o   = (state_q == ST_DONE);
        result_o = res_q;
        ovf_o    = ovf_q;
        unf_o    = unf_q;
    end

    // ---------------- assertions ----------------
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    a_r6_ovf_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (result_o[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}));

    a_r7_unf_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && unf_o) |-> (result_o == '0));

    a_r2_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ZCHK && (un_zero[0] || un_zero[1])) |=> (done_o && !ovf_o && !unf_o));

    a_r3_align_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN && !exp_equal) |=>
            (done_o ||
             ((ea_q == $past(ea_q) + 1'b1) && $stable(eb_q)) ||
             ((eb_q == $past(eb_q) + 1'b1) && $stable(ea_q))));

    a_r7_norm_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && !norm_done && !unf_now) |=>
            (state_q == ST_NORM && re_q == $past(re_q) - 1'b1));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> ($stable(w_q[0]) && $stable(w_q[1])));
endmodule

// File: tb/fp_iter_addsub_tb.sv
`timescale 1ns/1ps
module fp_iter_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sub_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] result_o;
    logic        done_o, ovf_o, unf_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fp_iter_addsub u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
        .done_o(done_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        sub;
        logic [31:0] res;
        logic        ovf;
        logic        unf;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{32'h40000000, 32'h40000000, 1'b0, 32'h40800000, 1'b0, 1'b0},
        '{32'h40400000, 32'h3F000000, 1'b0, 32'h40600000, 1'b0, 1'b0},
        '{32'h40000000, 32'h40000000, 1'b1, 32'h00000000, 1'b0, 1'b0},
        '{32'h40000000, 32'h3FC00000, 1'b1, 32'h3F000000, 1'b0, 1'b0},
        '{32'h3FC00000, 32'h40000000, 1'b1, 32'hBF000000, 1'b0, 1'b0},
        '{32'h00000000, 32'hC1123456, 1'b0, 32'hC1123456, 1'b0, 1'b0},
        '{32'h410ABCDE, 32'h80000007, 1'b1, 32'h410ABCDE, 1'b0, 1'b0},
        '{32'h00000000, 32'h40900000, 1'b1, 32'hC0900000, 1'b0, 1'b0},
        '{32'h50000000, 32'h327FFFFF, 1'b0, 32'h50000000, 1'b0, 1'b0},
        '{32'h4B000000, 32'h3FFFFFFF, 1'b0, 32'h4B000001, 1'b0, 1'b0},
        '{32'h4B800000, 32'h3FFFFFFF, 1'b0, 32'h4B800000, 1'b0, 1'b0},
        '{32'h7FC00000, 32'h7FC00000, 1'b0, 32'h7F800000, 1'b1, 1'b0},
        '{32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, 1'b1, 1'b0},
        '{32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1},
        '{32'h01000000, 32'h00800000, 1'b1, 32'h00800000, 1'b0, 1'b0},
        '{32'h40000000, 32'h3F800001, 1'b0, 32'h40400000, 1'b0, 1'b0},
        '{32'hC0800000, 32'h40000000, 1'b0, 32'hC0000000, 1'b0, 1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R6 carry renormalize";
            1:       return "R3 alignment";
            2:       return "R5 exact zero";
            3:       return "R1 subtract";
            4:       return "R9 sign of larger";
            5:       return "R2 first operand zero";
            6:       return "R8 zero by exponent field";
            7:       return "R1 subtract from zero";
            8:       return "R4 alignment flush";
            9:       return "R3 shift distance 23";
            10:      return "R4 shift distance 24";
            11:      return "R6 overflow";
            12:      return "R6 negative overflow";
            13:      return "R7 underflow";
            14:      return "R7 minimum exponent";
            15:      return "R9 truncation";
            default: return "R9 negative larger";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          output logic [31:0] r, output logic ov, output logic un, output bit got);
        @(negedge clk);
        opa_i = a; opb_i = b; sub_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 200 && !got; k++) begin
            if (done_o) got = 1'b1;
            else @(negedge clk);
        end
        r = result_o; ov = ovf_o; un = unf_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        ov, un;
        bit          got;
        int          pulses;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(done_o == 1'b0, "R10 reset done", {31'b0, done_o}, 32'h0);
        check(result_o == 32'h0, "R10 reset result", result_o, 32'h0);
        check(ovf_o == 1'b0 && unf_o == 1'b0, "R10 reset flags", {30'b0, ovf_o, unf_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].a, VEC[i].b, VEC[i].sub, r, ov, un, got);
            check(got, {vec_tag(i), " done seen"}, {31'b0, got}, 32'h1);
            check(r == VEC[i].res, {vec_tag(i), " result"}, r, VEC[i].res);
            check(ov == VEC[i].ovf, {vec_tag(i), " ovf"}, {31'b0, ov}, {31'b0, VEC[i].ovf});
            check(un == VEC[i].unf, {vec_tag(i), " unf"}, {31'b0, un}, {31'b0, VEC[i].unf});
            @(negedge clk);
            check(done_o == 1'b0, "R10 done single cycle", {31'b0, done_o}, 32'h0);
        end

        // R10: start pulses during a long alignment are ignored
        @(negedge clk);
        opa_i = 32'h50000000; opb_i = 32'h327FFFFF; sub_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        opa_i = 32'h40000000; opb_i = 32'h40000000; sub_i = 1'b1;
        repeat (5) @(negedge clk);
        start_i = 1'b0;
        pulses = 0;
        r = '0;
        for (int k = 0; k < 100; k++) begin
            if (done_o) begin
                pulses++;
                r = result_o;
            end
            @(negedge clk);
        end
        check(pulses == 1, "R10 busy start ignored, done count", pulses, 32'd1);
        check(r == 32'h50000000, "R10 busy start ignored, result", r, 32'h50000000);

        // R2: both operands zero returns the second word
        run_op(32'h00000000, 32'h00000000, 1'b1, r, ov, un, got);
        check(got && r == 32'h80000000, "R2 both zero", r, 32'h80000000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule